// File: doc/BRIEF.md
# Retransmit Wait Sequencer

This block steps a packet transmitter through the wait that follows each transmission when an acknowledgment is expected. When the transmitter reports that a packet has gone out, the block drives the radio into receive for a fixed minimum listen window. If a packet is still arriving when that window closes, receive is held until the packet ends. The radio is then parked in standby for whatever is left of a programmable retransmit delay. When the delay is used up, the block switches the radio to transmit and pulses a retransmit strobe. A received acknowledgment during the listen phase ends the sequence quietly.

The delay is programmed as a small code in fixed steps and counted in microsecond ticks from the end of transmission. Some combinations of data rate and acknowledgment-payload length need a longer delay than the shortest code gives. Such a combination raises a sticky configuration-error flag, and the block substitutes the floor value for that sequence. The RF front end, packet framing and retry counting sit outside this block.

Top module: `retx_delay_seq`

## Requirements
- R1: After reset the radio mode output reads idle, the strobe is low and the error flag is low. The mode output is one-hot: bit 0 idle, bit 1 receive, bit 2 standby, bit 3 transmit.
- R2: A `tx_done` pulse seen in idle or transmit starts a sequence in receive and clears the tick count. Receive lasts until the count reaches 250 ticks, and the mode changes on the clock after that.
- R3: While `rx_busy` is high after the listen window, receive is held. The mode leaves receive on the first clock at which `rx_busy` is sampled low.
- R4: The delay is (code+1) × 250 ticks, counted from the start of the sequence. Standby lasts until the count reaches the delay. On the next clock the mode becomes transmit and `retx_strobe` is high for exactly one cycle.
- R5: When receive ends with the count already at or past the delay, the block goes straight from receive to transmit with the strobe and never enters standby. This includes a delay equal to the listen window.
- R6: `data_rate` encodes 00 = 1 Mbps, 01 = 2 Mbps, 10 = 250 kbps, and 11 is treated as 250 kbps. A delay below 500 ticks violates the floor at 250 kbps, at 2 Mbps with `ack_len` above 15, or at 1 Mbps with `ack_len` above 5. For a violating sequence the delay used is 500 ticks.
- R7: `cfg_err` rises when a sequence starts with a violating configuration. It stays high through later legal sequences until reset.
- R8: `ack_rcvd` during receive returns the mode to idle on the next clock, and no strobe follows. `ack_rcvd` in standby has no effect on the sequence.
- R9: `tx_done` during receive or standby is ignored, so the strobe timing of the running sequence is unchanged.
- R10: The count advances only on clocks where `us_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle microsecond tick |
| tx_done | input | 1 | Pulse at the end of a packet transmission |
| delay_code | input | CODE_W | Retransmit delay code, (code+1) steps |
| data_rate | input | 2 | Air data rate selector |
| ack_len | input | LEN_W | Expected acknowledgment payload length in bytes |
| rx_busy | input | 1 | A packet reception is in progress |
| ack_rcvd | input | 1 | Pulse when a valid acknowledgment arrives |
| radio_mode | output | 4 | One-hot radio mode |
| retx_strobe | output | 1 | One-cycle retransmit request |
| cfg_err | output | 1 | Sticky delay-floor violation flag |

## Verification
The bench builds the block with its default parameters: a 4-bit code, 250-tick steps, a 250-tick listen window and a 500-tick floor. With these, both payload-length limits and the code-0 floor case can be reached directly. Holding the tick high every clock makes each phase boundary land on a known clock, so receive-to-standby, standby-to-transmit and the skipped-standby cases are checked to the exact cycle. A run with ticks on alternate clocks shows that only ticks advance the timing.

// File: rtl/retx_pkg.sv
package retx_pkg;

    localparam int US_W = 16;
    typedef logic [US_W-1:0] us_t;

    typedef enum logic [1:0] {
        RATE_1M   = 2'b00,
        RATE_2M   = 2'b01,
        RATE_250K = 2'b10,
        RATE_RSV  = 2'b11
    } rate_e;

    typedef enum logic [3:0] {
        PH_IDLE = 4'b0001,
        PH_RX   = 4'b0010,
        PH_STBY = 4'b0100,
        PH_TX   = 4'b1000
    } phase_e;

    typedef struct packed {
        us_t  delay_us;
        logic viol;
    } dly_cfg_t;

    function automatic logic floor_applies(rate_e r, int unsigned len,
                                           int unsigned lim_2m, int unsigned lim_1m);
        case (r)
            RATE_1M: return len > lim_1m;
            RATE_2M: return len > lim_2m;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/retx_floor_chk.sv
module retx_floor_chk
    import retx_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int LEN_W    = 6,
    parameter int STEP_US  = 250,
    parameter int FLOOR_US = 500,
    parameter int LIM_2M   = 15,
    parameter int LIM_1M   = 5
) (
    input  logic [CODE_W-1:0] code,
    input  rate_e             rate,
    input  logic [LEN_W-1:0]  ack_len,
    output dly_cfg_t          cfg
);
    us_t  programmed;
    logic needs;

    always_comb begin
        programmed = (us_t'(code) + us_t'(1)) * us_t'(STEP_US);
        needs      = floor_applies(rate, 32'(ack_len), LIM_2M, LIM_1M);
        cfg.viol   = needs && (programmed < us_t'(FLOOR_US));
        cfg.delay_us = cfg.viol ? us_t'(FLOOR_US) : programmed;
    end

    always_comb begin
        a_r6_floor_met: assert (!needs || (cfg.delay_us >= us_t'(FLOOR_US)));
    end

endmodule

// File: rtl/retx_us_cnt.sv
module retx_us_cnt
    import retx_pkg::*;
#(
    parameter int SAT_US = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output us_t  elapsed
);
    always_ff @(posedge clk) begin
        if (rst)
            elapsed <= '0;
        else if (clr)
            elapsed <= '0;
        else if (run && tick && (elapsed < us_t'(SAT_US)))
            elapsed <= elapsed + us_t'(1);
    end

    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
        (!clr && !tick) |=> $stable(elapsed));

    a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
        elapsed <= us_t'(SAT_US));

endmodule

// File: rtl/retx_phase_fsm.sv
module retx_phase_fsm
    import retx_pkg::*;
#(
    parameter int LISTEN_US = 250
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_done,
    input  logic     rx_busy,
    input  logic     ack_rcvd,
    input  us_t      elapsed,
    input  dly_cfg_t cfg_in,
    output phase_e   phase,
    output logic     strobe,
    output logic     err,
    output logic     cnt_clr,
    output logic     cnt_run
);
    us_t  dly_q;
    logic listen_done;
    logic delay_done;

    assign cnt_clr     = ((phase == PH_IDLE) || (phase == PH_TX)) && tx_done;
    assign cnt_run     = (phase == PH_RX) || (phase == PH_STBY);
    assign listen_done = (elapsed >= us_t'(LISTEN_US)) && !rx_busy;
    assign delay_done  = elapsed >= dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            strobe <= 1'b0;
            err    <= 1'b0;
            dly_q  <= '0;
        end else begin
            strobe <= 1'b0;
            case (phase)
                PH_IDLE, PH_TX: begin
                    if (tx_done) begin
                        phase <= PH_RX;
                        dly_q <= cfg_in.delay_us;
                        if (cfg_in.viol)
                            err <= 1'b1;
                    end
                end
                PH_RX: begin
                    if (ack_rcvd) begin
                        phase <= PH_IDLE;
                    end else if (listen_done) begin
                        if (delay_done) begin
                            phase  <= PH_TX;
                            strobe <= 1'b1;
                        end else begin
                            phase <= PH_STBY;
                        end
                    end
                end
                PH_STBY: begin
                    if (delay_done) begin
                        phase  <= PH_TX;
                        strobe <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    a_r1_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(phase) == 1);

    a_r2_min_listen: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RX && !ack_rcvd && elapsed < us_t'(LISTEN_US)) |=> (phase == PH_RX));

    a_r3_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RX && !ack_rcvd && rx_busy) |=> (phase == PH_RX));

    a_r4_strobe_in_tx: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (phase == PH_TX));

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    a_r8_ack_abort: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RX && ack_rcvd) |=> (phase == PH_IDLE && !strobe));

    a_r9_busy_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STBY && tx_done && elapsed < dly_q) |=> (phase == PH_STBY));

endmodule

// File: rtl/retx_delay_seq.sv
module retx_delay_seq
    import retx_pkg::*;
#(
    parameter int CODE_W    = 4,
    parameter int LEN_W     = 6,
    parameter int STEP_US   = 250,
    parameter int LISTEN_US = 250,
    parameter int FLOOR_US  = 500,
    parameter int LIM_2M    = 15,
    parameter int LIM_1M    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              tx_done,
    input  logic [CODE_W-1:0] delay_code,
    input  logic [1:0]        data_rate,
    input  logic [LEN_W-1:0]  ack_len,
    input  logic              rx_busy,
    input  logic              ack_rcvd,
    output logic [3:0]        radio_mode,
    output logic              retx_strobe,
    output logic              cfg_err
);
    localparam int MAX_DLY_US = (2 ** CODE_W) * STEP_US;
    localparam int SAT_US     = (MAX_DLY_US > FLOOR_US) ? MAX_DLY_US : FLOOR_US;

    dly_cfg_t cfg;
    us_t      elapsed;
    phase_e   phase;
    logic     cnt_clr;
    logic     cnt_run;

    retx_floor_chk #(
        .CODE_W  (CODE_W),
        .LEN_W   (LEN_W),
        .STEP_US (STEP_US),
        .FLOOR_US(FLOOR_US),
        .LIM_2M  (LIM_2M),
        .LIM_1M  (LIM_1M)
    ) u_floor (
        .code    (delay_code),
        .rate    (rate_e'(data_rate)),
        .ack_len (ack_len),
        .cfg     (cfg)
    );

    retx_us_cnt #(
        .SAT_US(SAT_US)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .run     (cnt_run),
        .tick    (us_tick),
        .elapsed (elapsed)
    );

    retx_phase_fsm #(
        .LISTEN_US(LISTEN_US)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tx_done  (tx_done),
        .rx_busy  (rx_busy),
        .ack_rcvd (ack_rcvd),
        .elapsed  (elapsed),
        .cfg_in   (cfg),
        .phase    (phase),
        .strobe   (retx_strobe),
        .err      (cfg_err),
        .cnt_clr  (cnt_clr),
        .cnt_run  (cnt_run)
    );

    assign radio_mode = phase;

endmodule

// File: tb/retx_delay_seq_test.sv
module retx_delay_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       us_tick = 1'b0;
    logic       tx_done = 1'b0;
    logic [3:0] delay_code = '0;
    logic [1:0] data_rate = 2'b00;
    logic [5:0] ack_len = '0;
    logic       rx_busy = 1'b0;
    logic       ack_rcvd = 1'b0;
    logic [3:0] radio_mode;
    logic       retx_strobe;
    logic       cfg_err;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    localparam logic [3:0] M_IDLE = 4'b0001;
    localparam logic [3:0] M_RX   = 4'b0010;
    localparam logic [3:0] M_STBY = 4'b0100;
    localparam logic [3:0] M_TX   = 4'b1000;

    retx_delay_seq uut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .tx_done(tx_done),
        .delay_code(delay_code), .data_rate(data_rate), .ack_len(ack_len),
        .rx_busy(rx_busy), .ack_rcvd(ack_rcvd), .radio_mode(radio_mode),
        .retx_strobe(retx_strobe), .cfg_err(cfg_err)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; tx_done = 1'b0; rx_busy = 1'b0; ack_rcvd = 1'b0; us_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Runs one sequence; k counts clock edges after the edge that takes tx_done.
    task automatic run_seq(input string tag, input int code, input int rate, input int len,
                           input int busy_until, input int ack_at, input int txd_at,
                           input bit alt, input int exp_strobe, input int exp_stby,
                           input int exp_err);
        int strobe_at = -1;
        int stby_at = -1;
        int n_strobe = 0;
        int limit;
        limit = ((exp_strobe > 0) ? exp_strobe : 1100) + 30;
        @(negedge clk);
        delay_code = 4'(code); data_rate = 2'(rate); ack_len = 6'(len);
        tx_done = 1'b1; us_tick = alt ? 1'b0 : 1'b1;
        rx_busy = (busy_until >= 0); ack_rcvd = 1'b0;
        for (int k = 0; k <= limit; k++) begin
            @(negedge clk);
            if (retx_strobe) begin
                n_strobe++;
                if (strobe_at < 0) strobe_at = k;
            end
            if (radio_mode == M_STBY && stby_at < 0) stby_at = k;
            tx_done  = ((k + 1) == txd_at);
            us_tick  = alt ? (((k + 1) % 2) == 1) : 1'b1;
            rx_busy  = ((k + 1) <= busy_until);
            ack_rcvd = ((k + 1) == ack_at);
        end
        tx_done = 1'b0; rx_busy = 1'b0; ack_rcvd = 1'b0;
        chk({tag, " strobe cycle"}, strobe_at, exp_strobe);
        chk({tag, " standby entry"}, stby_at, exp_stby);
        chk({tag, " strobe count"}, n_strobe, (exp_strobe >= 0) ? 1 : 0);
        chk({tag, " cfg_err"}, int'(cfg_err), exp_err);
        chk({tag, " final mode"}, int'(radio_mode), (exp_strobe >= 0) ? int'(M_TX) : int'(M_IDLE));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk("R1 reset mode idle", int'(radio_mode), int'(M_IDLE));
        chk("R1 reset strobe", int'(retx_strobe), 0);
        chk("R1 reset cfg_err", int'(cfg_err), 0);
    endtask

    task automatic t_basic();
        // R2 R4: 1000-tick delay, standby after listen window
        run_seq("R2 R4 basic", 3, 0, 0, -1, -1, -1, 1'b0, 1001, 251, 0);
    endtask

    task automatic t_listen_equal();
        // R5: delay equals listen window, no standby
        run_seq("R5 equal", 0, 0, 5, -1, -1, -1, 1'b0, 251, -1, 0);
    endtask

    task automatic t_busy_short();
        // R3: busy extends receive into standby later
        run_seq("R3 busy", 3, 0, 0, 400, -1, -1, 1'b0, 1001, 401, 0);
    endtask

    task automatic t_busy_past();
        // R5: busy past the delay, straight to transmit
        run_seq("R5 busy past", 1, 0, 0, 600, -1, -1, 1'b0, 601, -1, 0);
    endtask

    task automatic t_ack();
        // R8: ack in receive aborts, ack in standby ignored
        run_seq("R8 ack rx", 1, 0, 0, -1, 100, -1, 1'b0, -1, -1, 0);
        run_seq("R8 ack stby", 3, 0, 0, -1, 300, -1, 1'b0, 1001, 251, 0);
    endtask

    task automatic t_restart_ignored();
        // R9: tx_done in receive and in standby does not restart
        run_seq("R9 txd rx", 1, 0, 0, -1, -1, 100, 1'b0, 501, 251, 0);
        run_seq("R9 txd stby", 1, 0, 0, -1, -1, 300, 1'b0, 501, 251, 0);
    endtask

    task automatic t_floor();
        do_reset();
        run_seq("R6 2M len15 legal", 0, 1, 15, -1, -1, -1, 1'b0, 251, -1, 0);
        run_seq("R6 1M len6 floor", 0, 0, 6, -1, -1, -1, 1'b0, 501, 251, 1);
        run_seq("R7 sticky after legal", 2, 0, 0, -1, -1, -1, 1'b0, 751, 251, 1);
        do_reset();
        @(negedge clk);
        chk("R7 reset clears cfg_err", int'(cfg_err), 0);
        run_seq("R6 2M len16 floor", 0, 1, 16, -1, -1, -1, 1'b0, 501, 251, 1);
        do_reset();
        run_seq("R6 250k code0 floor", 0, 2, 0, -1, -1, -1, 1'b0, 501, 251, 1);
        do_reset();
        run_seq("R6 rate11 code0 floor", 0, 3, 0, -1, -1, -1, 1'b0, 501, 251, 1);
        do_reset();
        run_seq("R6 250k code1 legal", 1, 2, 0, -1, -1, -1, 1'b0, 501, 251, 0);
    endtask

    task automatic t_tick_gaps();
        // R10: ticks on alternate clocks double every phase
        do_reset();
        run_seq("R10 alt ticks", 1, 0, 0, -1, -1, -1, 1'b1, 1000, 500, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_listen_equal();
        t_busy_short();
        t_busy_past();
        t_ack();
        t_restart_ignored();
        t_floor();
        t_tick_gaps();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule